// File: doc/BRIEF.md
# Three-Wire DAC Code and Output Mode Control Port

This block receives command words over a three-wire serial link (an active-low frame enable, a serial clock and a data line) and turns them into an 8-bit code for an auxiliary DAC and a flag that forces the video outputs to ground. The three serial lines are oversampled by the block clock through a synchronizer. Every decision is taken on clean edges inside the block clock domain.

A frame opens when the enable falls. While the enable is low, each rising serial clock shifts one data bit into a 12-bit window, most significant bit first. When the enable rises, the window is committed, provided at least three serial clocks arrived. Bit 10 of the word decides whether the low byte replaces the held DAC code, and each such replacement emits a one-cycle load pulse. Bit 11 stores the programmed output mode. Two pins take precedence over the serial setting and act without a clock: a global-control pin and a mode-switch pin.

Top module: `ctl3w_port`

## Requirements
- R1: After reset the held DAC code is 0x00, the programmed mode is normal and `dac_load_o` is low. With `glob_ctl_i` high, `gnd_force_o` is therefore low.
- R2: A frame word is 12 bits, sent bit 11 first and bit 0 last. Bits 7..0 form the DAC code, with bit 7 as its MSB. Bits 9..8 have no effect on any output.
- R3: When a committed word has bit 10 = 1, `dac_code_o` takes bits 7..0 and `dac_load_o` is high for exactly one clock. When bit 10 = 0, `dac_code_o` keeps its value and no load pulse occurs.
- R4: A committed word stores bit 11 as the programmed mode (0 = normal, 1 = grounded). While `glob_ctl_i` is high, `gnd_force_o` equals the programmed mode.
- R5: While `glob_ctl_i` is low, the programmed mode has no effect. With `mode_sw_i` high, `gnd_force_o` is low. The programmed mode stays stored and takes effect again once `glob_ctl_i` returns high.
- R6: While `glob_ctl_i` and `mode_sw_i` are both low, `gnd_force_o` is high. It follows the pins combinationally, with no clock edge needed.
- R7: A word commits only on the rising edge of the enable. If fewer than 3 serial clock rises occurred since the enable fell, the frame is discarded: neither the DAC code nor the programmed mode changes, and no load pulse occurs.
- R8: If more than 12 bits are shifted, the last 12 received form the committed word.
- R9: A frame with exactly 3 serial clocks is valid. The shift window is cleared when a frame opens, so such a word holds the 3 received bits in bits 2..0 and zeros above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sen_ni | input | 1 | Frame enable, active low; its rising edge commits the frame |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdi_i | input | 1 | Serial data, MSB first |
| glob_ctl_i | input | 1 | High: the serial mode bit rules; low: `mode_sw_i` rules |
| mode_sw_i | input | 1 | Mode pin used while `glob_ctl_i` is low (1 = normal) |
| dac_code_o | output | 8 | Held auxiliary DAC code |
| dac_load_o | output | 1 | One-cycle pulse when the DAC code register is written |
| gnd_force_o | output | 1 | Forces the video outputs to ground when high |

## Verification
The bench builds the port with its default parameters: a 12-bit word, an 8-bit code, a three-clock minimum frame and a two-stage synchronizer. With a minimum of three clocks, the bench can run frames of two and three clocks, one on each side of the boundary. With a 12-bit window, a 15-bit frame shows that the oldest bits drop out. The two-stage synchronizer keeps commit latency at a few block clocks, so each result can be checked shortly after the enable rises, well before the next frame.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int unsigned WORD_W_DEF   = 12;
  localparam int unsigned CODE_W_DEF   = 8;
  localparam int unsigned MIN_CLKS_DEF = 3;
  localparam int unsigned SYNC_DEF     = 2;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_GROUND = 1'b1
  } out_mode_e;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ctl3w_frame.sv
module ctl3w_frame #(
  parameter int unsigned WORD_W   = 12,
  parameter int unsigned MIN_CLKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sen_fall_i,
  input  logic              sen_rise_i,
  input  logic              sclk_rise_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  localparam int unsigned CNT_W = $clog2(MIN_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_CLKS);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shift_q  <= '0;
    end else if (sen_fall_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      shift_q  <= '0;
    end else if (sen_rise_i) begin
      active_q <= 1'b0;
    end else if (active_q && sclk_rise_i) begin
      shift_q <= {shift_q[WORD_W-2:0], sdi_i};
      // saturate: only "reached minimum" matters
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o   = shift_q;
  assign commit_o = sen_rise_i && active_q && (cnt_q == CNT_SAT);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_SAT); // R7
  AST_CLEAR_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_fall_i |=> (shift_q == '0 && cnt_q == '0)); // R9
endmodule

// File: rtl/ctl3w_commit.sv
module ctl3w_commit
  import ctl3w_pkg::*;
#(
  parameter int unsigned WORD_W   = 12,
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned LOAD_BIT = 10,
  parameter int unsigned MODE_BIT = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              dac_load_o,
  output out_mode_e         mode_o
);
  logic [CODE_W-1:0] code_q;
  logic              load_q;
  out_mode_e         mode_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          code_q <= '0;
    else if (commit_i && word_i[LOAD_BIT]) code_q <= word_i[CODE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= commit_i && word_i[LOAD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       mode_q <= MODE_NORMAL;
    else if (commit_i) mode_q <= out_mode_e'(word_i[MODE_BIT]);

  assign dac_code_o = code_q;
  assign dac_load_o = load_q;
  assign mode_o     = mode_q;

  AST_CODE_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> load_q); // R3
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q); // R3
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(code_q) && $stable(mode_q))); // R7
endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
  import ctl3w_pkg::*;
#(
  parameter int unsigned WORD_W      = WORD_W_DEF,
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned MIN_CLKS    = MIN_CLKS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sen_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              glob_ctl_i,
  input  logic              mode_sw_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              dac_load_o,
  output logic              gnd_force_o
);
  localparam int unsigned MODE_BIT = WORD_W - 1;
  localparam int unsigned LOAD_BIT = WORD_W - 2;

  logic       sen_s;
  logic [1:0] ser_s;
  logic       sen_d, sclk_d;
  logic       sen_fall, sen_rise, sclk_rise;
  logic [WORD_W-1:0] word;
  logic       commit;
  out_mode_e  prog_mode;

  ctl3w_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b1)) u_sync_sen (
    .clk_i, .rst_ni, .d_i(sen_ni), .q_o(sen_s)
  );
  ctl3w_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b00)) u_sync_ser (
    .clk_i, .rst_ni, .d_i({sclk_i, sdi_i}), .q_o(ser_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sen_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      sen_d  <= sen_s;
      sclk_d <= ser_s[1];
    end

  assign sen_fall  = sen_d && !sen_s;
  assign sen_rise  = !sen_d && sen_s;
  assign sclk_rise = !sclk_d && ser_s[1];

  ctl3w_frame #(.WORD_W(WORD_W), .MIN_CLKS(MIN_CLKS)) u_frame (
    .clk_i, .rst_ni,
    .sen_fall_i(sen_fall), .sen_rise_i(sen_rise),
    .sclk_rise_i(sclk_rise), .sdi_i(ser_s[0]),
    .word_o(word), .commit_o(commit)
  );

  ctl3w_commit #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .LOAD_BIT(LOAD_BIT), .MODE_BIT(MODE_BIT)
  ) u_commit (
    .clk_i, .rst_ni, .commit_i(commit), .word_i(word),
    .dac_code_o, .dac_load_o, .mode_o(prog_mode)
  );

  // pin override is combinational: no clock needed to ground outputs
  always_comb begin
    if (glob_ctl_i) gnd_force_o = (prog_mode == MODE_GROUND);
    else            gnd_force_o = !mode_sw_i;
  end

  AST_PIN_GND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_ctl_i && !mode_sw_i) |-> gnd_force_o); // R6
  AST_PIN_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_ctl_i && mode_sw_i) |-> !gnd_force_o); // R5
endmodule

// File: tb/sim_ctl3w_port.sv
module sim_ctl3w_port;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sen_ni = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic glob = 1'b1, msw = 1'b1;
  logic [7:0] code;
  logic load, gnd;

  int n_run = 0, n_fail = 0, load_cnt = 0;

  always #4 clk = ~clk;

  ctl3w_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sen_ni(sen_ni), .sclk_i(sclk), .sdi_i(sdi),
    .glob_ctl_i(glob), .mode_sw_i(msw),
    .dac_code_o(code), .dac_load_o(load), .gnd_force_o(gnd)
  );

  always @(negedge clk) if (load) load_cnt++;

  typedef struct packed {
    logic [4:0]  nbits;
    logic [15:0] word;
    logic        glob;
    logic        msw;
    logic [7:0]  code;
    logic        gnd;
    logic        load;
  } vec_t;

  // R2 R3 R4 R7 R9 R8 R5 vectors
  localparam vec_t VECS [9] = '{
    '{5'd12, 16'h04A5, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b1},  // R2 R3 load A5
    '{5'd12, 16'h0B3C, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0},  // R4 R3 grounded, no load
    '{5'd12, 16'h075A, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b1},  // R2 bits 9..8 ignored
    '{5'd12, 16'h0C81, 1'b1, 1'b1, 8'h81, 1'b1, 1'b1},  // R4 R3 both
    '{5'd2,  16'h0000, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0},  // R7 short frame dropped
    '{5'd3,  16'h0000, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0},  // R9 3 clocks valid
    '{5'd15, 16'h74F0, 1'b1, 1'b1, 8'hF0, 1'b0, 1'b1},  // R8 last 12 bits
    '{5'd12, 16'h0800, 1'b0, 1'b1, 8'hF0, 1'b0, 1'b0},  // R5 serial mode ignored
    '{5'd2,  16'h0000, 1'b1, 1'b1, 8'hF0, 1'b1, 1'b0}   // R5 stored mode returns
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nb, input logic [15:0] w);
    sen_ni = 1'b0;
    wait_clks(4);
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = w[i];
      wait_clks(4);
      sclk = 1'b1;
      wait_clks(4);
      sclk = 1'b0;
    end
    wait_clks(4);
    sen_ni = 1'b1;
    wait_clks(10);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_clks(3);
    rst_ni = 1'b1;
    wait_clks(2);
    chk("R1 code", code, 8'h00);
    chk("R1 gnd", gnd, 1'b0);
    chk("R1 load", load, 1'b0);

    for (int v = 0; v < 9; v++) begin
      glob = VECS[v].glob;
      msw  = VECS[v].msw;
      load_cnt = 0;
      send(int'(VECS[v].nbits), VECS[v].word);
      chk($sformatf("vec%0d code", v), code, VECS[v].code);
      chk($sformatf("vec%0d gnd", v), gnd, VECS[v].gnd);
      chk($sformatf("vec%0d load pulses", v), load_cnt, 32'(VECS[v].load));
    end

    // R6: pins ground outputs with no clock edge in between
    @(negedge clk);
    glob = 1'b0; msw = 1'b0;
    #1;
    chk("R6 async ground", gnd, 1'b1);
    msw = 1'b1;
    #1;
    chk("R5 pin normal", gnd, 1'b0);
    glob = 1'b1;
    #1;
    chk("R4 programmed ground", gnd, 1'b1);

    // R1: reset mid-run
    wait_clks(2);
    rst_ni = 1'b0;
    wait_clks(2);
    rst_ni = 1'b1;
    wait_clks(2);
    chk("R1 code after reset", code, 8'h00);
    chk("R1 gnd after reset", gnd, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule